// File: doc/BRIEF.md
# Per-State Byte Pre-Hash Filter

This block is a fast negative filter placed in front of the per-state lookup of a multi-pattern string-matching automaton. For every automaton state it keeps a small membership vector in on-chip storage. Each vector has one bit for each hash bucket of input characters. A bucket's bit is set when some character in that bucket moves the automaton forward, either from the state itself or from any state along its recursive failure chain. Failure links that end at the root add nothing to the vector.

On each request the block looks up the vector of the current state. It hashes each offered byte to a bucket by taking the byte's low bits, and tests the matching bit. A clear bit proves that no match can continue from that byte, so the controller goes straight to the root lookup path. A set bit is reported as a hit. A hit may be a false positive, and it obliges the controller to run the full per-state lookup. Two bytes are tested in each operation against the same state vector. Vectors are computed offline and loaded through a simple write port. While the controller is at the root state it raises a bypass input, and the filter then gives no verdict.

Top module: `prehash_filter`

## Requirements
- R1: Byte lane k is `in_bytes[8k+7:8k]`. Its bucket index is the low log2(VEC_W) bits of that byte, and the index selects one bit of the current state's vector. With the default VEC_W = 32 these are bits [4:0]; for example, 0x45 and 0x25 both map to bucket 5.
- R2: When the selected bit is 1, the lane's `hit` bit is 1 and its `nonhit` bit is 0. This applies to aliased characters as well.
- R3: When the selected bit is 0, the lane's `nonhit` bit is 1 and its `hit` bit is 0.
- R4: Results are registered. They appear one rising edge after the edge that samples `req_valid`, and not before it. `done` is high for exactly the cycles that follow a sampled request, so an isolated request gives a one-cycle pulse.
- R5: `hit` and `nonhit` are never both set in any lane, and both are 0 whenever `done` is 0.
- R6: A request made while `at_root` is 1 still raises `done`, but `hit` and `nonhit` stay all-zero.
- R7: Each lane is tested on its own against the vector of the same `cur_state`, so the two lanes may give different verdicts.
- R8: A write with `wr_en` replaces the vector of `wr_state` at the clock edge. A request made in the same cycle as a write to the same state sees the old vector. Requests made from the next cycle on see the new vector.
- R9: While `rst_n` is 0, `hit`, `nonhit` and `done` are all 0.
- R10: VEC_W may be 8, 16 or 32. With VEC_W = 8 the bucket is the low three bits of the byte, so 0x45 and 0x4D share bucket 5 and 0x46 falls in bucket 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the result registers |
| req_valid | input | 1 | Request strobe |
| at_root | input | 1 | Current state is the root; bypass the filter |
| cur_state | input | STATE_W | State whose vector is tested |
| in_bytes | input | 8*LANES | Offered bytes, lane 0 in the low byte |
| wr_en | input | 1 | Vector write enable |
| wr_state | input | STATE_W | State whose vector is written |
| wr_vec | input | VEC_W | Vector value to store |
| hit | output | LANES | Per-lane hit (possible continuation) |
| nonhit | output | LANES | Per-lane true negative |
| done | output | 1 | Verdict valid pulse |

## Verification
Every verdict and the `done` strobe are due exactly one rising edge after the request is sampled. The bench drives inputs on the falling edge and samples on the next falling edge, which is one edge later. It also probes shortly after driving to confirm that nothing appears early. A write issued alongside a request is due at the same edge but is visible only to the following request, so the bench checks both of those requests. The zero state during reset and the drop of `done` one cycle after an isolated request are checked at those exact falling edges.

// File: rtl/prehash_filter.sv
module prehash_filter #(
  parameter int STATE_W = 8,
  parameter int VEC_W   = 32,
  parameter int LANES   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 at_root,
  input  logic [STATE_W-1:0]   cur_state,
  input  logic [8*LANES-1:0]   in_bytes,
  input  logic                 wr_en,
  input  logic [STATE_W-1:0]   wr_state,
  input  logic [VEC_W-1:0]     wr_vec,
  output logic [LANES-1:0]     hit,
  output logic [LANES-1:0]     nonhit,
  output logic                 done
);

  localparam int IDX_W = $clog2(VEC_W);
  localparam int DEPTH = 1 << STATE_W;

  logic [VEC_W-1:0] vec_mem [DEPTH];
  logic [VEC_W-1:0] cur_vec;
  logic [LANES-1:0] probe;
  logic             active;

  always_ff @(posedge clk)
    if (wr_en) vec_mem[wr_state] <= wr_vec;

  assign cur_vec = vec_mem[cur_state];
  assign active  = req_valid & ~at_root;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [IDX_W-1:0] idx;
    logic [VEC_W-1:0] onehot;
    assign idx      = in_bytes[8*g +: IDX_W];
    assign onehot   = {{(VEC_W-1){1'b0}}, 1'b1} << idx;
    assign probe[g] = |(cur_vec & onehot);
  end

  wire unused_bytes = ^in_bytes;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit    <= '0;
      nonhit <= '0;
      done   <= 1'b0;
    end else begin
      hit    <= active ? probe  : '0;
      nonhit <= active ? ~probe : '0;
      done   <= req_valid;
    end
  end

  p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit & nonhit) == '0);

  p_quiet_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (hit == '0 && nonhit == '0));

  p_req_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> done);

  p_no_req_no_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !done);

  p_root_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && at_root) |=> (hit == '0 && nonhit == '0));

  p_full_verdict_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !at_root) |=> ((hit ^ nonhit) == {LANES{1'b1}}));

endmodule

// File: tb/prehash_filter_bench.sv
module prehash_filter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        at_root = 1'b0;
  logic [7:0]  cur_state = '0;
  logic [15:0] in_bytes = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_state = '0;
  logic [31:0] wr_vec = '0;
  logic        w8_wr_en = 1'b0;
  logic [7:0]  w8_wr_vec = '0;
  logic [1:0]  hit, nonhit, hit8, nonhit8;
  logic        done, done8;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  prehash_filter u_prehash_filter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .at_root(at_root),
    .cur_state(cur_state), .in_bytes(in_bytes), .wr_en(wr_en),
    .wr_state(wr_state), .wr_vec(wr_vec), .hit(hit), .nonhit(nonhit), .done(done));

  prehash_filter #(.VEC_W(8)) u_prehash_filter_w8 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .at_root(at_root),
    .cur_state(cur_state), .in_bytes(in_bytes), .wr_en(w8_wr_en),
    .wr_state(wr_state), .wr_vec(w8_wr_vec), .hit(hit8), .nonhit(nonhit8), .done(done8));

  // state, root, byte1, byte0, exp hit, exp nonhit
  localparam int NV = 10;
  localparam logic [28:0] TBL [NV] = '{
    {8'd1, 1'b0, 8'h48, 8'h45, 2'b11, 2'b00},
    {8'd1, 1'b0, 8'h47, 8'h45, 2'b01, 2'b10},
    {8'd1, 1'b0, 8'h28, 8'h25, 2'b11, 2'b00},
    {8'd1, 1'b0, 8'h18, 8'h05, 2'b01, 2'b10},
    {8'd2, 1'b0, 8'hFF, 8'h20, 2'b11, 2'b00},
    {8'd2, 1'b0, 8'h01, 8'h3E, 2'b00, 2'b11},
    {8'd3, 1'b0, 8'h12, 8'h34, 2'b11, 2'b00},
    {8'd4, 1'b0, 8'h12, 8'h34, 2'b00, 2'b11},
    {8'd1, 1'b1, 8'h48, 8'h45, 2'b00, 2'b00},
    {8'd4, 1'b1, 8'h12, 8'h34, 2'b00, 2'b00}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] st, input logic [31:0] v);
    wr_en = 1'b1; wr_state = st; wr_vec = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ask(input logic [7:0] st, input logic root, input logic [15:0] b);
    req_valid = 1'b1; cur_state = st; at_root = root; in_bytes = b;
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R9: outputs held at zero during reset, even with a request present
    req_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 reset outputs", {3'b0, done, hit, nonhit}, 8'h00);
    chk("R9 reset outputs w8", {3'b0, done8, hit8, nonhit8}, 8'h00);
    req_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    load(8'd1, 32'h0000_0120);
    load(8'd2, 32'h8000_0001);
    load(8'd3, 32'hFFFF_FFFF);
    load(8'd4, 32'h0000_0000);
    load(8'd5, 32'h0000_0000);
    w8_wr_en = 1'b1; wr_state = 8'd1; w8_wr_vec = 8'b0010_0000;
    @(negedge clk);
    w8_wr_en = 1'b0;

    // R4: nothing visible before the capturing edge
    req_valid = 1'b1; cur_state = 8'd1; at_root = 1'b0; in_bytes = 16'h4845;
    #1;
    chk("R4 not early", {7'b0, done}, 8'h00);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);

    // R1 R2 R3 R6 R7 table walk, back-to-back requests
    for (int i = 0; i < NV; i++) begin
      ask(TBL[i][28:21], TBL[i][20], TBL[i][19:4]);
      chk($sformatf("R1/R2/R3/R6/R7 vec %0d", i), {3'b0, done, hit, nonhit},
          {3'b0, 1'b1, TBL[i][3:2], TBL[i][1:0]});
    end

    // R4 R5: isolated request then idle
    req_valid = 1'b0;
    @(negedge clk);
    chk("R4 done one cycle", {3'b0, done, hit, nonhit}, 8'h00);
    @(negedge clk);
    chk("R5 idle quiet", {3'b0, done, hit, nonhit}, 8'h00);

    // R8: write and request to same state in same cycle -> old vector
    wr_en = 1'b1; wr_state = 8'd5; wr_vec = 32'hFFFF_FFFF;
    ask(8'd5, 1'b0, 16'h1234);
    wr_en = 1'b0;
    chk("R8 same-cycle old", {3'b0, done, hit, nonhit}, {3'b0, 1'b1, 2'b00, 2'b11});
    ask(8'd5, 1'b0, 16'h1234);
    chk("R8 next-cycle new", {3'b0, done, hit, nonhit}, {3'b0, 1'b1, 2'b11, 2'b00});

    // R10: 8-bit vector, bucket from low three bits
    ask(8'd1, 1'b0, 16'h4D45);
    chk("R10 w8 alias hit", {3'b0, done8, hit8, nonhit8}, {3'b0, 1'b1, 2'b11, 2'b00});
    chk("R1 w32 same bytes", {3'b0, done, hit, nonhit}, {3'b0, 1'b1, 2'b01, 2'b10});
    ask(8'd1, 1'b0, 16'h4546);
    chk("R10 w8 split", {3'b0, done8, hit8, nonhit8}, {3'b0, 1'b1, 2'b10, 2'b01});
    ask(8'd1, 1'b1, 16'h4546);
    chk("R6 w8 root bypass", {3'b0, done8, hit8, nonhit8}, {3'b0, 1'b1, 2'b00, 2'b00});
    req_valid = 1'b0;
    @(negedge clk);
    chk("R4 w8 done drop", {7'b0, done8}, 8'h00);

    finish_run();
  end

endmodule